// File: doc/BRIEF.md
# Eight-Channel Converter Scan Master

This block is the host side of a serial link to an eight-input, 12-bit successive-approximation converter. It generates the serial clock (idle low, data launched on falling edges and captured on rising edges), drives chip select and the command line, and reads the returned bit stream. Software-free configuration is provided on plain input vectors: a per-channel enable mask, a per-channel range bit and a per-channel polarity bit.

While `scan_en` is high and at least one channel is enabled, the block opens a session, sends a run of zero bits so that the converter is known to be waiting for a start bit, and then issues one command byte every 18 serial clocks. Each command byte is placed so that it overlaps the tail of the previous result, which gives the highest conversion rate the converter allows with a free-running serial clock. Every finished conversion is written out as a one-cycle record holding the channel number, the raw 12-bit code and a 16-bit value that is zero-extended for unipolar channels and sign-extended for bipolar ones.

Top module: `adcscan_master`

## Requirements
- R1: While reset is asserted, and afterwards until a scan starts, `spi_cs_n` is high, `spi_sclk` is low, `spi_mosi` is low and `rec_valid` is low.
- R2: The serial clock is low whenever `spi_cs_n` is high; while a session runs, each low and each high phase lasts exactly `HALF_DIV` system clocks (13 by default, giving about 1.92 MHz from 50 MHz).
- R3: A session starts by driving `spi_cs_n` low and sending 18 serial clock periods with `spi_mosi` low, so the first start bit is seen on the 19th rising edge of the session.
- R4: Each command byte is sent most significant bit first as: a 1 start bit, the 3-bit channel number, the channel's range bit, the channel's polarity bit, then 0 and 1 (external conversion clock, no power-down). `spi_mosi` changes only while `spi_sclk` is low.
- R5: Successive start bits are exactly 18 rising edges apart, and `spi_cs_n` stays low for the whole session, rising only together with a falling serial clock edge.
- R6: `spi_miso` is captured on rising serial clock edges; a result is 12 bits, most significant first, taken on rising edges 13 to 18 of the frame that carried its command and edges 1 to 6 of the following frame.
- R7: Channels are visited in ascending order among those enabled, wrapping from 7 to the lowest enabled one; a mask change takes effect at the next frame boundary; with an empty mask no session is opened.
- R8: Each record is a single-cycle `rec_valid` pulse tagged with the channel whose command produced it; in steady state records are spaced 18 x 2 x `HALF_DIV` system clocks apart (468 by default).
- R9: The bits returned during the first frame of a session are discarded, so the first record of a session belongs to the first channel scanned.
- R10: `rec_value` equals the code zero-extended when the polarity bit sent with that conversion was 0, and sign-extended (two's complement) when it was 1.
- R11: When `scan_en` falls or the mask becomes empty, the current frame is finished, a short trailing period with `spi_mosi` low collects the last result, that result is recorded, and then `spi_cs_n` rises; no issued conversion is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scan_en | input | 1 | Keep scanning while high |
| ch_enable | input | NUM_CH | Channels taking part in the scan |
| ch_range | input | NUM_CH | Range bit sent with each channel's command |
| ch_bipolar | input | NUM_CH | Polarity bit per channel; 1 selects two's complement |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Command bits to the converter |
| spi_miso | input | 1 | Result bits from the converter |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_ch | output | CH_W | Channel that produced the record |
| rec_code | output | RES_W | Raw 12-bit result |
| rec_value | output | OUT_W | Code extended according to polarity |

## Verification
The checker watches every cycle for the serial clock's half-period width and its idle-low state outside a session, for command data that never moves while the clock is high, for chip select rising only at a falling clock edge, for records that are single pulses, and for the extension bits of each record agreeing with its code. Which channel a record belongs to, the exact command bytes, the 18-zero lead-in, the discard of the first frame, the wrap-around order after a mask change and the loss-free shutdown all depend on a converter answering on the wire, so only the bench's scenarios against its converter model can show them.

// File: rtl/adcscan_pkg.sv
package adcscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_CONV  = 2'd2,
    ST_DRAIN = 2'd3
  } scan_state_e;

  // Low two bits of every command: external conversion clock, stay powered.
  localparam logic [1:0] MODE_EXT_CLK = 2'b01;
  localparam int         CTRL_W       = 8;

  function automatic logic [CTRL_W-1:0] make_ctrl(input logic [2:0] ch,
                                                  input logic       rng,
                                                  input logic       bip);
    return {1'b1, ch, rng, bip, MODE_EXT_CLK};
  endfunction

endpackage

// File: rtl/adcscan_sclk_gen.sv
module adcscan_sclk_gen #(
  parameter int HALF_DIV = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  always_comb begin
    tick     = run && (div_q == DIV_W'(HALF_DIV - 1));
    rise_evt = tick && !sclk_q;
    fall_evt = tick && sclk_q;
    if (!run) begin
      div_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      div_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      div_d  = div_q + 1'b1;
      sclk_d = sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

endmodule

// File: rtl/adcscan_chan_pick.sv
module adcscan_chan_pick #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   from,
  output logic [CH_W-1:0]   pick,
  output logic              any
);
  // Lowest offset from 'from' wins, so walk offsets downward.
  always_comb begin
    int idx;
    pick = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      idx = (int'(from) + k) % NUM_CH;
      if (mask[idx]) pick = CH_W'(idx);
    end
    any = |mask;
  end

endmodule

// File: rtl/adcscan_capture.sv
module adcscan_capture #(
  parameter int RES_W = 12,
  parameter int OUT_W = 16,
  parameter int CH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             done,
  input  logic             miso,
  input  logic [CH_W-1:0]  tag_ch,
  input  logic             tag_bip,
  output logic             rec_valid,
  output logic [CH_W-1:0]  rec_ch,
  output logic [RES_W-1:0] rec_code,
  output logic [OUT_W-1:0] rec_value
);
  logic [RES_W-2:0] sh_q, sh_d;
  logic [RES_W-1:0] word;
  logic [OUT_W-1:0] ext;

  always_comb begin
    word = {sh_q, miso};
    sh_d = shift_en ? word[RES_W-2:0] : sh_q;
  end

  generate
    if (OUT_W > RES_W) begin : g_ext
      assign ext = {{(OUT_W-RES_W){tag_bip & word[RES_W-1]}}, word};
    end else begin : g_same
      assign ext = word[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      rec_valid <= 1'b0;
      rec_ch    <= '0;
      rec_code  <= '0;
      rec_value <= '0;
    end else begin
      sh_q      <= sh_d;
      rec_valid <= done;
      if (done) begin
        rec_ch    <= tag_ch;
        rec_code  <= word;
        rec_value <= ext;
      end
    end
  end

endmodule

// File: rtl/adcscan_master.sv
module adcscan_master
  import adcscan_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int HALF_DIV  = 13,
  parameter int RES_W     = 12,
  parameter int OUT_W     = 16,
  parameter int FRAME_LEN = 18,
  parameter int OVERLAP   = 6,
  parameter int CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] ch_range,
  input  logic [NUM_CH-1:0] ch_bipolar,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              rec_valid,
  output logic [CH_W-1:0]   rec_ch,
  output logic [RES_W-1:0]  rec_code,
  output logic [OUT_W-1:0]  rec_value
);
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int CAP_START = FRAME_LEN - (RES_W - OVERLAP);
  localparam int CAP_TAIL  = OVERLAP;

  scan_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CH_W-1:0]   cur_ch_q, cur_ch_d, prv_ch_q, prv_ch_d;
  logic              cur_rng_q, cur_rng_d, cur_bip_q, cur_bip_d;
  logic              prv_bip_q, prv_bip_d, prv_vld_q, prv_vld_d;
  logic              run, rise_evt, fall_evt, reg_en;
  logic              at_frame_end, at_tail_end;
  logic [CH_W-1:0]   pick_from, pick_ch;
  logic              pick_any;
  logic [CTRL_W-1:0] ctrl;
  logic [2:0]        bit_sel;
  logic              shift_en, done;

  assign run = (state_q != ST_IDLE);

  adcscan_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(spi_sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  always_comb begin
    if (state_q == ST_LEAD || cur_ch_q == CH_W'(NUM_CH - 1)) pick_from = '0;
    else                                                     pick_from = cur_ch_q + 1'b1;
  end

  adcscan_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .mask(ch_enable), .from(pick_from), .pick(pick_ch), .any(pick_any)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    cur_ch_d  = cur_ch_q;
    cur_rng_d = cur_rng_q;
    cur_bip_d = cur_bip_q;
    prv_ch_d  = prv_ch_q;
    prv_bip_d = prv_bip_q;
    prv_vld_d = prv_vld_q;
    at_frame_end = (idx_q == IDX_W'(FRAME_LEN - 1));
    at_tail_end  = (idx_q == IDX_W'(CAP_TAIL - 1));
    if (state_q == ST_IDLE) begin
      idx_d     = '0;
      prv_vld_d = 1'b0;
      if (scan_en && pick_any) state_d = ST_LEAD;
    end else if (fall_evt) begin
      if (state_q == ST_DRAIN && at_tail_end) begin
        state_d = ST_IDLE;
        idx_d   = '0;
      end else if (at_frame_end) begin
        idx_d     = '0;
        prv_ch_d  = cur_ch_q;
        prv_bip_d = cur_bip_q;
        prv_vld_d = (state_q == ST_CONV);
        if (scan_en && pick_any && state_q != ST_DRAIN) begin
          state_d   = ST_CONV;
          cur_ch_d  = pick_ch;
          cur_rng_d = ch_range[pick_ch];
          cur_bip_d = ch_bipolar[pick_ch];
        end else begin
          state_d = ST_DRAIN;
        end
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  assign reg_en = fall_evt || (state_q == ST_IDLE);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      cur_ch_q  <= '0;
      cur_rng_q <= 1'b0;
      cur_bip_q <= 1'b0;
      prv_ch_q  <= '0;
      prv_bip_q <= 1'b0;
      prv_vld_q <= 1'b0;
    end else if (reg_en) begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      cur_ch_q  <= cur_ch_d;
      cur_rng_q <= cur_rng_d;
      cur_bip_q <= cur_bip_d;
      prv_ch_q  <= prv_ch_d;
      prv_bip_q <= prv_bip_d;
      prv_vld_q <= prv_vld_d;
    end
  end

  // Command bit for the current serial period
  always_comb begin
    ctrl     = make_ctrl(3'(cur_ch_q), cur_rng_q, cur_bip_q);
    bit_sel  = 3'd7 - idx_q[2:0];
    spi_mosi = (state_q == ST_CONV) && (idx_q < IDX_W'(CTRL_W)) && ctrl[bit_sel];
    spi_cs_n = (state_q == ST_IDLE);
  end

  // Result bit window spans the frame boundary
  always_comb begin
    shift_en = rise_evt && run &&
               ((idx_q >= IDX_W'(CAP_START)) || (idx_q < IDX_W'(CAP_TAIL)));
    done     = rise_evt && prv_vld_q && at_tail_end &&
               (state_q == ST_CONV || state_q == ST_DRAIN);
  end

  adcscan_capture #(.RES_W(RES_W), .OUT_W(OUT_W), .CH_W(CH_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .done(done),
    .miso(spi_miso), .tag_ch(prv_ch_q), .tag_bip(prv_bip_q),
    .rec_valid(rec_valid), .rec_ch(rec_ch), .rec_code(rec_code),
    .rec_value(rec_value)
  );

endmodule

// File: rtl/adcscan_master_chk.sv
module adcscan_master_chk #(
  parameter int HALF_DIV = 13,
  parameter int RES_W    = 12,
  parameter int OUT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_sclk,
  input logic             spi_cs_n,
  input logic             spi_mosi,
  input logic             rec_valid,
  input logic [RES_W-1:0] rec_code,
  input logic [OUT_W-1:0] rec_value
);
  localparam int CNT_W = $clog2(HALF_DIV + 2);

  logic             sclk_d;
  logic [CNT_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      sclk_d <= spi_sclk;
      if (spi_cs_n)                 hold_cnt <= '0;
      else if (spi_sclk != sclk_d)  hold_cnt <= CNT_W'(1);
      else if (hold_cnt < CNT_W'(HALF_DIV + 1)) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R2
  sclk_half_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk != sclk_d) |-> hold_cnt == CNT_W'(HALF_DIV));

  // R4
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R5
  cs_release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (!spi_sclk && $past(spi_sclk)));

  // R8
  rec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  // R10
  rec_extension_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_value[RES_W-1:0] == rec_code) &&
                  ((rec_value[OUT_W-1:RES_W] == '0) ||
                   (rec_value[OUT_W-1:RES_W] == {(OUT_W-RES_W){rec_code[RES_W-1]}})));

endmodule

bind adcscan_master adcscan_master_chk #(
  .HALF_DIV(HALF_DIV), .RES_W(RES_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .rec_valid(rec_valid), .rec_code(rec_code),
  .rec_value(rec_value)
);

// File: tb/adcscan_master_test.sv
module adcscan_master_test;
  localparam int HALF = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_en;
  logic [7:0]  ch_enable, ch_range, ch_bipolar;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        rec_valid;
  logic [2:0]  rec_ch;
  logic [11:0] rec_code;
  logic [15:0] rec_value;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adcscan_master uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .ch_enable(ch_enable),
    .ch_range(ch_range), .ch_bipolar(ch_bipolar), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .rec_valid(rec_valid), .rec_ch(rec_ch), .rec_code(rec_code),
    .rec_value(rec_value)
  );

  // ---------------- converter model ----------------
  logic [11:0] samp [8];
  bit          act = 0;
  int          cnt = 0, left = 0, rises = 0;
  logic [7:0]  rxb = 8'h00;
  logic [11:0] dw = 12'h000;
  int          nstart = 0, nconv = 0;
  int          start_at [256];
  logic [7:0]  byte_log [256];

  function automatic logic [11:0] model_code(input logic [7:0] b);
    if (b[1:0] != 2'b01) return 12'h000;
    return samp[b[6:4]] ^ (b[3] ? 12'h00F : 12'h000) ^ (b[2] ? 12'h010 : 12'h000);
  endfunction

  always @(posedge spi_sclk or negedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n === 1'b1) begin
      act = 0; cnt = 0; left = 0; rises = 0; spi_miso = 1'b0;
    end else if (spi_sclk === 1'b1) begin
      rises++;
      if ((!act || cnt >= 18) && spi_mosi === 1'b1) begin
        act = 1; cnt = 1; rxb = 8'h01;
        if (nstart < 256) start_at[nstart] = rises;
        nstart++;
      end else if (act) begin
        cnt++;
        if (cnt <= 8) rxb = {rxb[6:0], spi_mosi};
      end
    end else if (spi_sclk === 1'b0) begin
      if (act && cnt == 12) begin
        dw = model_code(rxb);
        spi_miso = dw[11];
        dw = {dw[10:0], 1'b0};
        left = 11;
        if (nconv < 256) byte_log[nconv] = rxb;
        nconv++;
      end else if (left > 0) begin
        spi_miso = dw[11];
        dw = {dw[10:0], 1'b0};
        left--;
      end else begin
        spi_miso = 1'b0;
      end
    end
  end

  // ---------------- record monitor ----------------
  int          nrec = 0, csl = 0;
  logic [2:0]  r_ch   [256];
  logic [11:0] r_code [256];
  logic [15:0] r_val  [256];
  int          r_t    [256];

  always @(negedge clk) begin
    if (spi_cs_n === 1'b0) csl++;
    if (rst_n === 1'b1 && rec_valid === 1'b1) begin
      if (nrec < 256) begin
        r_ch[nrec] = rec_ch; r_code[nrec] = rec_code;
        r_val[nrec] = rec_value; r_t[nrec] = cyc;
      end
      nrec++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [11:0] exp_code(input int ch);
    return samp[ch] ^ (ch_range[ch] ? 12'h00F : 12'h000) ^ (ch_bipolar[ch] ? 12'h010 : 12'h000);
  endfunction

  function automatic logic [15:0] exp_val(input int ch);
    logic [11:0] c;
    c = exp_code(ch);
    return ch_bipolar[ch] ? {{4{c[11]}}, c} : {4'h0, c};
  endfunction

  task automatic wait_recs(input int target, input string req);
    int n = 0;
    while (nrec < target && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(nrec >= target, req, nrec, target);
  endtask

  task automatic stop_scan(input string req);
    int n = 0;
    @(negedge clk);
    scan_en = 1'b0;
    while (spi_cs_n !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
    check(spi_cs_n === 1'b1, req, spi_cs_n, 1);
  endtask

  task automatic check_rec(input int i, input int ch, input string req);
    check(r_ch[i] == 3'(ch), {req, " channel"}, r_ch[i], ch);
    check(r_code[i] == exp_code(ch) && r_val[i] == exp_val(ch),
          {req, " code/value"}, {r_code[i], r_val[i]}, {exp_code(ch), exp_val(ch)});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    scan_en = 1'b0; ch_enable = 8'h00; ch_range = 8'h00; ch_bipolar = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_mosi === 1'b0 && rec_valid === 1'b0,
          "R1 reset outputs", {spi_cs_n, spi_sclk, spi_mosi, rec_valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check(spi_cs_n === 1'b1 && csl == 0, "R1 idle after reset", csl, 0);
  endtask

  task automatic t_empty_mask();
    int c0 = csl;
    int r0 = nrec;
    ch_enable = 8'h00;
    scan_en = 1'b1;
    repeat (2000) @(negedge clk);
    check(csl == c0 && nrec == r0, "R7 empty mask opens no session", csl - c0, 0);
    scan_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_full_scan();
    int b = nrec;
    int bs = nstart;
    int bc = nconv;
    int hi = 0;
    int lo = 0;
    for (int i = 0; i < 8; i++) samp[i] = 12'h111 * i + 12'h0A3;
    samp[0] = 12'h000;
    samp[1] = 12'hFF0;
    ch_enable = 8'hFF; ch_range = 8'hAA; ch_bipolar = 8'h00;
    scan_en = 1'b1;
    while (spi_sclk !== 1'b1) @(negedge clk);
    while (spi_sclk === 1'b1) begin hi++; @(negedge clk); end
    while (spi_sclk === 1'b0) begin lo++; @(negedge clk); end
    check(hi == HALF && lo == HALF, "R2 half periods", {hi[15:0], lo[15:0]}, {16'(HALF), 16'(HALF)});
    wait_recs(b + 10, "R8 records arrive");
    stop_scan("R11 chip select released");
    for (int i = 0; i < 10; i++) check_rec(b + i, i % 8, "R6 R7 R9 unipolar scan");
    check(start_at[bs] == 19, "R3 first start bit rise", start_at[bs], 19);
    check(start_at[bs + 1] == 37, "R5 second start bit rise", start_at[bs + 1], 37);
    check(byte_log[bc] == 8'h81, "R4 command byte ch0", byte_log[bc], 8'h81);
    check(byte_log[bc + 1] == 8'h99, "R4 command byte ch1", byte_log[bc + 1], 8'h99);
    check(r_t[b + 1] - r_t[b] == 36 * HALF, "R8 record spacing", r_t[b + 1] - r_t[b], 36 * HALF);
    check(nrec - b == nconv - bc, "R11 no lost conversion", nrec - b, nconv - bc);
  endtask

  task automatic t_bipolar_sparse();
    int b = nrec;
    int exp_ch [3] = '{2, 5, 7};
    samp[2] = 12'h810;
    samp[5] = 12'h7E0;
    samp[7] = 12'hFEF;
    ch_enable = 8'b1010_0100; ch_range = 8'b0010_0000; ch_bipolar = 8'hFF;
    @(negedge clk);
    scan_en = 1'b1;
    wait_recs(b + 6, "R8 bipolar records arrive");
    stop_scan("R11 release after bipolar scan");
    check(r_ch[b] == 3'd2, "R9 first record is first channel", r_ch[b], 2);
    for (int i = 0; i < 6; i++) check_rec(b + i, exp_ch[i % 3], "R7 R10 bipolar sparse");
    check(r_val[b] == 16'hF800, "R10 most negative", r_val[b], 16'hF800);
    check(r_val[b + 1] == 16'h07FF, "R10 most positive", r_val[b + 1], 16'h07FF);
  endtask

  task automatic t_remask();
    int b = nrec;
    int bc = nconv;
    samp[6] = 12'h123; samp[0] = 12'h456; samp[1] = 12'h789;
    ch_enable = 8'h40; ch_range = 8'h00; ch_bipolar = 8'h00;
    @(negedge clk);
    scan_en = 1'b1;
    wait_recs(b + 3, "R8 single channel records");
    for (int i = 0; i < 3; i++) check_rec(b + i, 6, "R7 single channel repeats");
    ch_enable = 8'h03;
    wait_recs(b + 7, "R8 records after mask change");
    stop_scan("R11 release after remask");
    check(r_ch[b + 5] <= 3'd1 && r_ch[b + 6] <= 3'd1 && r_ch[b + 5] != r_ch[b + 6],
          "R7 new mask alternates", {r_ch[b + 5], r_ch[b + 6]}, 6'o01);
    check(nrec - b == nconv - bc, "R11 final result recorded", nrec - b, nconv - bc);
  endtask

  initial begin
    t_reset();
    t_empty_mask();
    t_full_scan();
    t_bipolar_sparse();
    t_remask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule